// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block counts hardware events for a host agent. It holds a bank of eight 64-bit counters. Each counter watches one line of a 256-line event vector, and an 8-bit code chooses the line. Code zero makes a counter count clock cycles. Software uses a register bus with a 32-bit register path. The counters can also be reached through a single 64-bit access, or one 32-bit half at a time.

A counter advances only when four conditions hold together: the global run bit is set, the counter's own enable bit is set, the power-management override bit is set, and the selected event is present in that cycle. When a counter rolls over from all ones to zero, a sticky status bit is latched for it. The interrupt output is raised while any latched status bit is not masked.

The bus takes a request in any cycle and never stalls it. A read returns its data on `rsp_data` with `rsp_valid` high in the next cycle, and a write gives no response. There is no back-pressure, so the requester must accept a response in the cycle it appears. `rsp_data` holds its value until the next read.

Top module: `evc_unit`

## Requirements
- R1: After reset, the interrupt mask (0x1C70) reads 0xFF and every other register and counter reads zero. The read-only version register at 0x1CF0 returns the `VERSION` parameter, and `irq` is low.
- R2: Counter n sits at byte address 0x1D00+8n. A wide access (`bus_wide`=1) reads or writes all 64 bits. A narrow access to base+0 reaches bits [31:0], and one to base+4 reaches bits [63:32]. A narrow write leaves the other half unchanged.
- R3: Counter n takes its event code from bits [8*(n%4)+7 : 8*(n%4)] of the select register at 0x1C80+4*(n/4). Code 0 counts every enabled cycle. A code c>0 counts the enabled cycles in which `ev_in[c]` is high.
- R4: Bit 0 of the run register at 0x1C00 is the global enable. While it is 0, no counter changes except by a bus write.
- R5: Bit n of the enable register at 0x1C04 enables counter n. A disabled counter holds its value.
- R6: Bit 9 of the configuration register at 0x0534 is the power-management override. While it is 0, no counter advances. Only that bit is stored, and the rest of that register reads zero.
- R7: When a counter increments from all ones, it wraps to zero and sets status bit n at 0x1C78. The bit stays set until software clears it.
- R8: Writing 1 to bit n of 0x1C7C clears status bit n, and bits written with 0 are untouched. If a wrap and a clear of the same bit fall in the same cycle, the bit ends up set. The clear address reads zero.
- R9: `irq` is high exactly when some status bit is set whose mask bit (0x1C70, where 1 masks) is 0.
- R10: A bus write to a counter in the same cycle as an increment loads the written value, and no increment or wrap occurs.
- R11: Every read gives `rsp_valid` high for one cycle on the next clock, and writes give none. A narrow read returns its data in bits [31:0] with bits [63:32] zero. An unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data (narrow writes use bits [31:0]) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| ev_in | input | 256 | Event vector, one line per event code |
| irq | output | 1 | Unmasked overflow pending |

## Verification
The hardest situations to reach from the ports are a counter rollover, and a rollover that falls in the same cycle as a bus write to that counter or to the status-clear register. Counting up from zero would take 2^64 cycles. The stimulus therefore loads counters to a few counts below all ones, with the cycle event selected so the wrap cycle is known exactly. The directed part then places a status clear and a counter write on that cycle. The random phase keeps loading near-all-ones values while enables, event codes, masks and clears change, and a cycle-accurate reference model in the bench predicts every read and the interrupt line.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef logic [15:0] reg_addr_t;

  localparam reg_addr_t A_RUN    = 16'h1C00;
  localparam reg_addr_t A_CNTEN  = 16'h1C04;
  localparam reg_addr_t A_MASK   = 16'h1C70;
  localparam reg_addr_t A_STAT   = 16'h1C78;
  localparam reg_addr_t A_CLR    = 16'h1C7C;
  localparam reg_addr_t A_SEL0   = 16'h1C80;
  localparam reg_addr_t A_VER    = 16'h1CF0;
  localparam reg_addr_t A_CNT0   = 16'h1D00;
  localparam reg_addr_t A_CFG    = 16'h0534;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned PM_BIT  = 9;
  localparam int unsigned CNT_STRIDE = 8;
endpackage

// File: rtl/evc_ctrl_regs.sv
module evc_ctrl_regs
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned EV_W    = 8,
  parameter logic [31:0] VERSION = 32'h0001_0002
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  reg_addr_t                 addr,
  input  logic [REG_W-1:0]          wdata,
  input  logic [NUM_CNT-1:0]        status,
  output logic                      run_q,
  output logic                      pm_q,
  output logic [NUM_CNT-1:0]        en_q,
  output logic [NUM_CNT-1:0]        mask_q,
  output logic [NUM_CNT*EV_W-1:0]   codes,
  output logic [REG_W-1:0]          rd_data
);
  localparam int unsigned SEL_PER = REG_W / EV_W;
  localparam int unsigned SEL_N   = (NUM_CNT + SEL_PER - 1) / SEL_PER;

  logic [REG_W-1:0] sel_q [SEL_N];

  // run, per-counter enables, mask, power-management override
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pm_q   <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
    end else if (wr) begin
      if (addr == A_RUN)   run_q  <= wdata[0];
      if (addr == A_CFG)   pm_q   <= wdata[PM_BIT];
      if (addr == A_CNTEN) en_q   <= wdata[NUM_CNT-1:0];
      if (addr == A_MASK)  mask_q <= wdata[NUM_CNT-1:0];
    end
  end

  // packed event-select registers, one per group of SEL_PER counters
  for (genvar k = 0; k < SEL_N; k++) begin : g_sel
    localparam reg_addr_t SEL_A = A_SEL0 + 16'(4 * k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      sel_q[k] <= '0;
      else if (wr && addr == SEL_A)    sel_q[k] <= wdata;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_code
    assign codes[n*EV_W +: EV_W] = sel_q[n / SEL_PER][(n % SEL_PER)*EV_W +: EV_W];
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_RUN:   rd_data[0]           = run_q;
      A_CFG:   rd_data[PM_BIT]      = pm_q;
      A_CNTEN: rd_data[NUM_CNT-1:0] = en_q;
      A_MASK:  rd_data[NUM_CNT-1:0] = mask_q;
      A_STAT:  rd_data[NUM_CNT-1:0] = status;
      A_VER:   rd_data              = VERSION;
      default: rd_data              = '0;
    endcase
    for (int k = 0; k < SEL_N; k++) begin
      if (addr == A_SEL0 + 16'(4 * k)) rd_data = sel_q[k];
    end
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned EV_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [2**EV_W-1:0]   ev_vec,
  input  logic [EV_W-1:0]      code,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [CNT_W-1:0]     wdata,
  output logic [CNT_W-1:0]     value,
  output logic                 wrap
);
  localparam int unsigned HALF = CNT_W / 2;

  logic hit, inc, wr_any;

  // code zero is the cycle event
  assign hit    = (code == '0) || ev_vec[code];
  assign inc    = run && hit;
  assign wr_any = wr_lo || wr_hi;
  assign wrap   = inc && !wr_any && (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr_any) begin
      if (wr_lo) value[HALF-1:0]     <= wdata[HALF-1:0];
      if (wr_hi) value[CNT_W-1:HALF] <= wdata[CNT_W-1:HALF];
    end else if (inc) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
  parameter int unsigned NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] wrap,
  input  logic               clr_we,
  input  logic [NUM_CNT-1:0] clr_bits,
  input  logic [NUM_CNT-1:0] mask,
  output logic [NUM_CNT-1:0] status,
  output logic               irq
);
  logic [NUM_CNT-1:0] clr_vec;

  assign clr_vec = clr_we ? clr_bits : '0;

  // a wrap in the clearing cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | wrap;
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/evc_unit.sv
module evc_unit
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned EV_W    = 8,
  parameter logic [31:0] VERSION = 32'h0001_0002
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_wide,
  input  logic [15:0]        bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic               rsp_valid,
  output logic [CNT_W-1:0]   rsp_data,
  input  logic [2**EV_W-1:0] ev_in,
  output logic               irq
);
  localparam int unsigned HALF  = CNT_W / 2;
  localparam int unsigned IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam reg_addr_t   CNT_SPAN = 16'(CNT_STRIDE * NUM_CNT);

  logic                      wr, rd;
  logic                      glb_en, pm_ovr;
  logic [NUM_CNT-1:0]        cnt_en, irq_mask, status, wrap, cnt_wr_any;
  logic [NUM_CNT*EV_W-1:0]   codes;
  logic [REG_W-1:0]          reg_rd;
  logic [CNT_W-1:0]          cnt_val [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0]  cnt_flat;
  logic [CNT_W-1:0]          cnt_wd;
  reg_addr_t                 cnt_off;
  logic                      in_cnt, hi_half;
  logic [IDX_W-1:0]          cnt_idx;
  logic [CNT_W-1:0]          rd_mux;
  logic                      run_all;

  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign cnt_off = bus_addr - A_CNT0;
  assign in_cnt  = (bus_addr >= A_CNT0) && (cnt_off < CNT_SPAN);
  assign cnt_idx = cnt_off[IDX_W+2:3];
  assign hi_half = bus_addr[2];
  assign cnt_wd  = bus_wide ? bus_wdata : {bus_wdata[HALF-1:0], bus_wdata[HALF-1:0]};
  assign run_all = glb_en && pm_ovr;

  evc_ctrl_regs #(.NUM_CNT(NUM_CNT), .EV_W(EV_W), .VERSION(VERSION)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata[REG_W-1:0]),
    .status  (status),
    .run_q   (glb_en),
    .pm_q    (pm_ovr),
    .en_q    (cnt_en),
    .mask_q  (irq_mask),
    .codes   (codes),
    .rd_data (reg_rd)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic sel_n;
    assign sel_n = wr && in_cnt && (cnt_idx == IDX_W'(n));
    assign cnt_wr_any[n] = sel_n;

    evc_counter #(.CNT_W(CNT_W), .EV_W(EV_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_all && cnt_en[n]),
      .ev_vec (ev_in),
      .code   (codes[n*EV_W +: EV_W]),
      .wr_lo  (sel_n && (bus_wide || !hi_half)),
      .wr_hi  (sel_n && (bus_wide || hi_half)),
      .wdata  (cnt_wd),
      .value  (cnt_val[n]),
      .wrap   (wrap[n])
    );
    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_val[n];
  end

  evc_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .clr_we   (wr && bus_addr == A_CLR),
    .clr_bits (bus_wdata[NUM_CNT-1:0]),
    .mask     (irq_mask),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    if (in_cnt) begin
      if (bus_wide)     rd_mux = cnt_val[cnt_idx];
      else if (hi_half) rd_mux = {{HALF{1'b0}}, cnt_val[cnt_idx][CNT_W-1:HALF]};
      else              rd_mux = {{HALF{1'b0}}, cnt_val[cnt_idx][HALF-1:0]};
    end else begin
      rd_mux = {{(CNT_W-REG_W){1'b0}}, reg_rd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/evc_unit_chk.sv
module evc_unit_chk
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic                     bus_wide,
  input logic [15:0]              bus_addr,
  input logic [CNT_W-1:0]         bus_wdata,
  input logic                     rsp_valid,
  input logic                     irq,
  input logic                     glb,
  input logic                     pm,
  input logic [NUM_CNT-1:0]       status,
  input logic [NUM_CNT-1:0]       mask,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT-1:0]       cnt_wr
);
  assert_rsp_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  assert_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);

  assert_glb_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb && cnt_wr == '0) |=> $stable(cnt_flat));

  assert_pm_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm && cnt_wr == '0) |=> $stable(cnt_flat));

  assert_full_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(bus_valid && bus_write && bus_addr == A_CLR && bus_wdata[i]))
      |=> status[i]);

    assert_wr_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_wide && bus_addr == A_CNT0 + 16'(CNT_STRIDE * i))
      |=> cnt_flat[i*CNT_W +: CNT_W] == $past(bus_wdata));
  end
endmodule

bind evc_unit evc_unit_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_wide  (bus_wide),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rsp_valid (rsp_valid),
  .irq       (irq),
  .glb       (glb_en),
  .pm        (pm_ovr),
  .status    (status),
  .mask      (irq_mask),
  .cnt_flat  (cnt_flat),
  .cnt_wr    (cnt_wr_any)
);

// File: tb/sim_evc_unit.sv
`timescale 1ns/1ps
module sim_evc_unit;
  localparam logic [31:0] VER = 32'h0001_0002;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic [63:0]  bus_wdata = '0;
  logic         rsp_valid;
  logic [63:0]  rsp_data;
  logic [255:0] ev_in = '0;
  logic         irq;

  int nchk = 0, nerr = 0, cyc = 0;
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  evc_unit #(.VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ev_in(ev_in), .irq(irq)
  );

  // reference model built from the requirements
  logic [63:0] m_cnt [8];
  logic        m_run, m_pm;
  logic [7:0]  m_en, m_mask, m_stat;
  logic [31:0] m_sel [2];

  function automatic bit is_cnt(input logic [15:0] a);
    return (a >= 16'h1D00) && (a < 16'h1D40);
  endfunction

  function automatic logic [63:0] m_read(input logic [15:0] a, input logic w);
    int i;
    if (is_cnt(a)) begin
      i = int'((a - 16'h1D00) >> 3);
      if (w)         return m_cnt[i];
      else if (a[2]) return {32'h0, m_cnt[i][63:32]};
      else           return {32'h0, m_cnt[i][31:0]};
    end
    case (a)
      16'h1C00: return {63'h0, m_run};
      16'h0534: return 64'(m_pm) << 9;
      16'h1C04: return {56'h0, m_en};
      16'h1C70: return {56'h0, m_mask};
      16'h1C78: return {56'h0, m_stat};
      16'h1C80: return {32'h0, m_sel[0]};
      16'h1C84: return {32'h0, m_sel[1]};
      16'h1CF0: return {32'h0, VER};
      default:  return 64'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] wrapv;
    logic [7:0] code;
    logic hit, inc, wr, wlo, whi;
    logic [63:0] wd;
    if (!rst_n) begin
      for (int n = 0; n < 8; n++) m_cnt[n] = '0;
      m_run = 0; m_pm = 0; m_en = 0; m_mask = 8'hFF; m_stat = 0;
      m_sel[0] = 0; m_sel[1] = 0;
    end else begin
      wr = bus_valid && bus_write;
      wd = bus_wide ? bus_wdata : {bus_wdata[31:0], bus_wdata[31:0]};
      wrapv = 0;
      for (int n = 0; n < 8; n++) begin
        code = m_sel[n/4][8*(n%4) +: 8];
        hit  = (code == 0) || ev_in[code];
        inc  = m_run && m_pm && m_en[n] && hit;
        wlo  = wr && is_cnt(bus_addr) && ((bus_addr - 16'h1D00) >> 3) == 16'(n)
               && (bus_wide || !bus_addr[2]);
        whi  = wr && is_cnt(bus_addr) && ((bus_addr - 16'h1D00) >> 3) == 16'(n)
               && (bus_wide || bus_addr[2]);
        if (wlo || whi) begin
          if (wlo) m_cnt[n][31:0]  = wd[31:0];
          if (whi) m_cnt[n][63:32] = wd[63:32];
        end else if (inc) begin
          if (m_cnt[n] == '1) wrapv[n] = 1'b1;
          m_cnt[n] = m_cnt[n] + 1;
        end
      end
      if (wr && bus_addr == 16'h1C7C) m_stat = m_stat & ~bus_wdata[7:0];
      m_stat = m_stat | wrapv;
      if (wr) begin
        case (bus_addr)
          16'h1C00: m_run  = bus_wdata[0];
          16'h0534: m_pm   = bus_wdata[9];
          16'h1C04: m_en   = bus_wdata[7:0];
          16'h1C70: m_mask = bus_wdata[7:0];
          16'h1C80: m_sel[0] = bus_wdata[31:0];
          16'h1C84: m_sel[1] = bus_wdata[31:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [63:0] d, input logic w);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_wide = w; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic w, input string tag,
                        output logic [63:0] got);
    logic [63:0] exp;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_wide = w; bus_addr = a;
    exp = m_read(a, w);
    @(posedge clk); #1;
    bus_valid = 0;
    check({tag, " rsp_valid"}, {63'h0, rsp_valid}, 64'h1);
    check(tag, rsp_data, exp);
    got = rsp_data;
  endtask

  // random events every cycle
  always @(negedge clk) begin
    for (int k = 0; k < 8; k++) ev_in[32*k +: 32] <= $urandom;
  end

  // interrupt line against the model
  always @(negedge clk) begin
    if (mon_on && rst_n) check("R9 irq", {63'h0, irq}, {63'h0, |(m_stat & ~m_mask)});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [63:0] g;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    bus_rd(16'h1C70, 0, "R1 mask", g);   check("R1 mask hard", g, 64'hFF);
    bus_rd(16'h1CF0, 0, "R1 version", g); check("R1 version hard", g, {32'h0, VER});
    bus_rd(16'h1C00, 0, "R1 run", g);    check("R1 run hard", g, 0);
    bus_rd(16'h1C78, 0, "R1 status", g); check("R1 status hard", g, 0);
    bus_rd(16'h1D18, 1, "R1 counter3", g); check("R1 counter3 hard", g, 0);
    check("R1 irq", {63'h0, irq}, 0);

    // R11 unmapped read, no response on write
    bus_rd(16'h1C10, 1, "R11 unmapped", g); check("R11 unmapped hard", g, 0);
    bus_wr(16'h1C04, 0, 0);
    check("R11 no rsp on write", {63'h0, rsp_valid}, 0);

    // R2 wide and half access
    bus_wr(16'h1D10, 64'h1122_3344_5566_7788, 1);
    bus_rd(16'h1D10, 0, "R2 low half", g);  check("R2 low hard", g, 64'h5566_7788);
    bus_rd(16'h1D14, 0, "R2 high half", g); check("R2 high hard", g, 64'h1122_3344);
    bus_wr(16'h1D14, 64'hAABB_CCDD, 0);
    bus_rd(16'h1D10, 1, "R2 wide", g); check("R2 wide hard", g, 64'hAABB_CCDD_5566_7788);

    // R3/R4 cycle counting over a known window
    bus_wr(16'h0534, 64'h200, 0);
    bus_wr(16'h1C04, 64'h01, 0);
    bus_wr(16'h1C00, 64'h1, 0);
    repeat (10) @(posedge clk);
    bus_wr(16'h1C00, 64'h0, 0);
    bus_rd(16'h1D00, 1, "R3 cycle code", g); check("R4 window count", g, 64'd11);

    // R6 override cleared blocks counting
    bus_wr(16'h0534, 64'h0, 0);
    bus_wr(16'h1C00, 64'h1, 0);
    repeat (5) @(posedge clk);
    bus_wr(16'h1C00, 64'h0, 0);
    bus_rd(16'h1D00, 1, "R6 pm off", g); check("R6 pm off hard", g, 64'd11);
    bus_wr(16'h0534, 64'hFFFF_FFFF, 0);
    bus_rd(16'h0534, 0, "R6 cfg readback", g); check("R6 cfg hard", g, 64'h200);

    // R5 per-counter enable off
    bus_wr(16'h1C04, 64'h0, 0);
    bus_wr(16'h1C00, 64'h1, 0);
    repeat (5) @(posedge clk);
    bus_wr(16'h1C00, 64'h0, 0);
    bus_rd(16'h1D00, 1, "R5 disabled", g); check("R5 disabled hard", g, 64'd11);

    // R3 event code selects an input line (counter 1, code 5; counter 6, code 0x9C)
    bus_wr(16'h1C80, 64'h0000_0500, 0);
    bus_wr(16'h1C84, 64'h009C_0000, 0);
    bus_wr(16'h1C04, 64'h42, 0);
    bus_wr(16'h1C00, 64'h1, 0);
    repeat (20) @(posedge clk);
    bus_wr(16'h1C00, 64'h0, 0);
    bus_rd(16'h1D08, 1, "R3 event 5", g);
    bus_rd(16'h1D30, 1, "R3 event 0x9C", g);

    // R7/R9 wrap of counter 1 on cycle code
    bus_wr(16'h1C80, 64'h0, 0);
    bus_wr(16'h1C04, 64'h02, 0);
    bus_wr(16'h1C70, 64'hFD, 0);
    bus_wr(16'h1D08, 64'hFFFF_FFFF_FFFF_FFFD, 1);
    bus_wr(16'h1C00, 64'h1, 0);
    repeat (6) @(posedge clk);
    bus_rd(16'h1C78, 0, "R7 status", g); check("R7 status hard", g, 64'h02);
    check("R9 irq set", {63'h0, irq}, 1);
    bus_wr(16'h1C70, 64'hFF, 0);
    check("R9 irq masked", {63'h0, irq}, 0);
    bus_wr(16'h1C70, 64'hFD, 0);
    // R10 write wins over a running increment
    bus_wr(16'h1D08, 64'h100, 1);
    bus_rd(16'h1D08, 1, "R10 priority", g); check("R10 priority hard", g, 64'h100);
    // R8 clear
    bus_wr(16'h1C7C, 64'h02, 0);
    bus_rd(16'h1C78, 0, "R8 cleared", g); check("R8 cleared hard", g, 0);
    check("R8 irq low", {63'h0, irq}, 0);
    bus_rd(16'h1C7C, 0, "R8 clear reads zero", g); check("R8 clr addr hard", g, 0);
    // R8 wrap and clear in one cycle: set wins
    bus_wr(16'h1D08, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    bus_wr(16'h1C7C, 64'h02, 0);
    bus_rd(16'h1C78, 0, "R8 set wins", g); check("R8 set wins hard", g, 64'h02);
    bus_wr(16'h1C00, 64'h0, 0);
    bus_wr(16'h1C7C, 64'hFF, 0);

    // random phase
    mon_on = 1'b1;
    for (int it = 0; it < 4000; it++) begin
      int op;
      logic [15:0] a;
      logic [63:0] d;
      op = int'($urandom % 12);
      case (op)
        0: bus_wr(16'h1C00, 64'($urandom % 4 != 0), 0);
        1: bus_wr(16'h1C04, 64'($urandom), 0);
        2: bus_wr(16'h1C70, 64'($urandom), 0);
        3: bus_wr(16'h1C80 + 16'(4 * ($urandom % 2)), 64'($urandom & 32'h0303_0303), 0);
        4: bus_wr(16'h0534, ($urandom % 5 != 0) ? 64'h200 : 64'h0, 0);
        5: bus_wr(16'h1C7C, 64'($urandom), 0);
        6, 7: begin
          a = 16'h1D00 + 16'(8 * ($urandom % 8));
          d = ($urandom % 2) ? {32'hFFFF_FFFF, 32'hFFFF_FFF0 | ($urandom % 16)}
                             : {$urandom, $urandom};
          if ($urandom % 3 == 0) bus_wr(a + 16'(4 * ($urandom % 2)), d, 0);
          else                   bus_wr(a, d, 1);
        end
        8, 9: begin
          a = 16'h1D00 + 16'(8 * ($urandom % 8));
          if ($urandom % 2) bus_rd(a, 1, "R2 R3 random counter", g);
          else              bus_rd(a + 16'(4 * ($urandom % 2)), 0, "R2 random half", g);
        end
        10: bus_rd(16'h1C78, 0, "R7 R8 random status", g);
        default: begin
          case ($urandom % 6)
            0: a = 16'h1C00;
            1: a = 16'h1C04;
            2: a = 16'h1C84;
            3: a = 16'h0534;
            4: a = 16'h1C20;
            default: a = 16'h1C70;
          endcase
          bus_rd(a, $urandom % 2, "R11 random register", g);
        end
      endcase
    end
    mon_on = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule